// File: doc/BRIEF.md
# MRU-Bit Replacement Selector

This block picks the way to evict in one set of an N-way set-associative cache. It keeps one recency flag per way. Every access to a way marks that way as recently used. When the last unmarked way gets marked, the whole vector resets so that only that way stays marked. The victim is the lowest-numbered way that is still unmarked.

The surrounding cache controller pulses the access strobe with the way index on every hit. It does the same on every fill of the victim chosen after a miss. It reads `victim_o` whenever it needs a replacement. The raw flag vector is exported so the recency state can be observed. Tag comparison, data storage, multiple sets and simultaneous accesses are outside this block.

Top module: `mru_plru_sel`

## Requirements
- R1: While `rst_ni` is low, every flag in `mru_o` is 0, and `victim_o` is 0 after reset is released.
- R2: A clock edge with `access_i` high sets bit `access_way_i` of `mru_o` (bit i belongs to way i).
- R3: If the access would leave all flags set, `mru_o` becomes a one-hot vector holding only the accessed way's bit after that edge.
- R4: An access to a way whose flag is already 1 leaves `mru_o` unchanged.
- R5: A clock edge with `access_i` low leaves `mru_o` unchanged.
- R6: `mru_o` is never all ones.
- R7: `victim_o` is the lowest way index whose flag in `mru_o` is 0. It is derived combinationally from the registered flags, so it follows `mru_o` in the same cycle.
- R8: A fill of the victim goes through the same access port. Filling the victim repeatedly from reset walks ways 0, 1, … N-1 in order, and the fill of way N-1 leaves only bit N-1 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| access_i | input | 1 | Access strobe: a hit or a fill of one way |
| access_way_i | input | $clog2(WAYS) | Way index of the access |
| victim_o | output | $clog2(WAYS) | Way to replace on a miss |
| mru_o | output | WAYS | Registered recency flags, bit i for way i |

## Verification
The flag vector is registered, so the effect of an access shows on `mru_o` one clock edge after the strobe is sampled. `victim_o` has no register of its own and changes in that same cycle. The bench drives the strobe on a falling edge and holds it for one rising edge. It checks both outputs on the following falling edge, when exactly one update has taken place. For each reachable starting vector and each way, the bench first rebuilds the vector and checks it. It then applies one access and compares the result with a model computed in the bench.

// File: rtl/mru_plru_pkg.sv
package mru_plru_pkg;
  parameter int unsigned DefWays = 8;

  typedef enum logic [1:0] {
    UPD_IDLE = 2'd0,
    UPD_SET  = 2'd1,
    UPD_HOLD = 2'd2,
    UPD_WRAP = 2'd3
  } upd_kind_e;
endpackage

// File: rtl/mru_flag_update.sv
module mru_flag_update
  import mru_plru_pkg::*;
#(
  parameter int unsigned WAYS = DefWays,
  localparam int unsigned IdxW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0] cur_i,
  input  logic            access_i,
  input  logic [IdxW-1:0] way_i,
  output logic [WAYS-1:0] nxt_o,
  output upd_kind_e       kind_o
);
  logic [WAYS-1:0] sel_oh;
  logic [WAYS-1:0] merged;

  always_comb begin
    sel_oh = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (IdxW'(i) == way_i) sel_oh[i] = 1'b1;
    end
  end

  assign merged = cur_i | sel_oh;

  always_comb begin
    if (!access_i) begin
      kind_o = UPD_IDLE;
      nxt_o  = cur_i;
    end else if (&merged) begin
      // last clear flag taken: keep only the accessed way
      kind_o = UPD_WRAP;
      nxt_o  = sel_oh;
    end else if (merged == cur_i) begin
      kind_o = UPD_HOLD;
      nxt_o  = cur_i;
    end else begin
      kind_o = UPD_SET;
      nxt_o  = merged;
    end
  end
endmodule

// File: rtl/mru_victim_enc.sv
module mru_victim_enc
  import mru_plru_pkg::*;
#(
  parameter int unsigned WAYS = DefWays,
  localparam int unsigned IdxW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0] flags_i,
  output logic [IdxW-1:0] victim_o
);
  logic [WAYS:0] found;

  assign found[0] = 1'b0;

  // lowest clear flag wins; a ripple chain marks the first hit
  for (genvar g = 0; g < WAYS; g++) begin : g_chain
    assign found[g+1] = found[g] | ~flags_i[g];
  end

  always_comb begin
    victim_o = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (!found[i] && !flags_i[i]) victim_o = IdxW'(i);
    end
  end
endmodule

// File: rtl/mru_plru_sel.sv
module mru_plru_sel
  import mru_plru_pkg::*;
#(
  parameter int unsigned WAYS = DefWays,
  localparam int unsigned IdxW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            access_i,
  input  logic [IdxW-1:0] access_way_i,
  output logic [IdxW-1:0] victim_o,
  output logic [WAYS-1:0] mru_o
);
  logic [WAYS-1:0] flags_q;
  logic [WAYS-1:0] flags_d;
  upd_kind_e       upd_kind;

  mru_flag_update #(.WAYS(WAYS)) u_upd (
    .cur_i    (flags_q),
    .access_i (access_i),
    .way_i    (access_way_i),
    .nxt_o    (flags_d),
    .kind_o   (upd_kind)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
    end else if (upd_kind != UPD_IDLE) begin
      flags_q <= flags_d;
    end
  end

  mru_victim_enc #(.WAYS(WAYS)) u_enc (
    .flags_i  (flags_q),
    .victim_o (victim_o)
  );

  assign mru_o = flags_q;
endmodule

// File: rtl/mru_plru_sel_chk.sv
module mru_plru_sel_chk #(
  parameter int unsigned WAYS = 8,
  localparam int unsigned IdxW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            access_i,
  input logic [IdxW-1:0] access_way_i,
  input logic [IdxW-1:0] victim_o,
  input logic [WAYS-1:0] mru_o
);
  logic [WAYS-1:0] below_mask;

  always_comb begin
    for (int i = 0; i < WAYS; i++) below_mask[i] = (IdxW'(i) < victim_o);
  end

  p_set_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access_i |=> mru_o[$past(access_way_i)]);

  p_wrap_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access_i && !mru_o[access_way_i] && $countones(mru_o) == WAYS - 1)
      |=> ($countones(mru_o) == 1));

  p_hit_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access_i && mru_o[access_way_i]) |=> $stable(mru_o));

  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !access_i |=> $stable(mru_o));

  p_never_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&mru_o));

  p_victim_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mru_o[victim_o]);

  p_victim_lowest_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mru_o & below_mask) == below_mask);
endmodule

bind mru_plru_sel mru_plru_sel_chk #(.WAYS(WAYS)) u_chk (.*);

// File: tb/mru_plru_sel_tb_top.sv
module mru_plru_sel_tb_top;
  localparam int unsigned WAYS = 8;
  localparam int unsigned IdxW = 3;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            access_i = 1'b0;
  logic [IdxW-1:0] access_way_i = '0;
  logic [IdxW-1:0] victim_o;
  logic [WAYS-1:0] mru_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  mru_plru_sel #(.WAYS(WAYS)) dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int low_zero(input int v);
    for (int i = 0; i < WAYS; i++) if (!v[i]) return i;
    return 0;
  endfunction

  function automatic int model_next(input int v, input int w);
    int n;
    n = v | (1 << w);
    if (n == 'hFF) n = 1 << w;
    return n;
  endfunction

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    access_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic touch(input int w);
    @(negedge clk_i);
    access_i = 1'b1;
    access_way_i = IdxW'(w);
    @(negedge clk_i);
    access_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int exp_v;
    // R1: reset state
    @(negedge clk_i);
    chk("R1 mru", int'(mru_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 victim", int'(victim_o), 0);

    // R5: idle cycles keep the vector
    touch(5);
    repeat (4) @(negedge clk_i);
    chk("R5 idle", int'(mru_o), 'h20);
    chk("R7 victim idle", int'(victim_o), 0);

    // R8: fill the victim repeatedly from reset
    do_reset();
    exp_v = 0;
    for (int k = 0; k < WAYS; k++) begin
      chk("R8 victim walk", int'(victim_o), k);
      touch(int'(victim_o));
      exp_v = model_next(exp_v, k);
      chk("R8 flags walk", int'(mru_o), exp_v);
    end
    chk("R8 wrap onehot", int'(mru_o), 'h80);

    // R2 R3 R4 R6 R7: every reachable start vector against every way
    for (int p = 0; p < 255; p++) begin
      for (int w = 0; w < WAYS; w++) begin
        do_reset();
        for (int b = 0; b < WAYS; b++) if (p[b]) touch(b);
        chk("R2 build", int'(mru_o), p);
        chk("R7 victim pre", int'(victim_o), low_zero(p));
        touch(w);
        exp_v = model_next(p, w);
        if (p[w]) chk("R4 hold", int'(mru_o), exp_v);
        else if ((p | (1 << w)) == 'hFF) chk("R3 wrap", int'(mru_o), exp_v);
        else chk("R2 set", int'(mru_o), exp_v);
        chk("R6 not full", int'(&mru_o), 0);
        chk("R7 victim post", int'(victim_o), low_zero(exp_v));
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule